// File: doc/BRIEF.md
# Skip-Test and MQ-Transfer Operate Unit

This unit executes the conditional-skip operate group and the MQ-transfer operate group of a 12-bit accumulator machine. Each instruction is presented together with the accumulator, the link, the MQ register and the already-incremented program counter. The unit returns the skip decision, the program counter that follows from it, the new accumulator and MQ values, and an illegal-instruction flag. All results are registered and appear one cycle after the instruction is accepted.

In the skip group, three condition bits test the accumulator sign, the accumulator for zero and the link. One sense bit picks the meaning. In the plain sense, any selected condition that holds causes a skip. In the inverted sense, the unit skips only when none of the selected conditions holds. The accumulator can be cleared after testing, and a halt request sets a sticky halt output that only the continue input releases. In the MQ group, the accumulator can be cleared first. The MQ is then ORed into the accumulator and the accumulator is copied into the MQ, both from the same starting values, so the two can be exchanged in one instruction. Switch-register reads and extended arithmetic are rejected as illegal.

Top module: `opr23_unit`

## Requirements
- R1: An instruction is accepted when `valid_i` is high at a rising clock edge. All of `res_valid_o`, `skip_o`, `pc_o`, `acc_o`, `mq_o` and `illegal_o` show the result after that same edge. `res_valid_o` is high for exactly that one cycle. While `valid_i` is low, the data outputs hold their values. After reset, every output is 0.
- R2: An instruction whose top three bits are not 7, or whose bit 8 is 0, sets `illegal_o`. It causes no skip and no halt, and the accumulator, MQ and PC pass through unchanged.
- R3: The skip group is encoded as bits 11:9 = 7, bit 8 = 1 and bit 0 = 0, with bit 3 = 0 for the plain sense. In the plain sense the unit skips if any of these holds: bit 6 is set and accumulator bit 11 is 1; bit 5 is set and the accumulator is zero; bit 4 is set and the link is 1.
- R4: In the skip group with bit 3 = 1 (inverted sense), the unit skips only if none of the conditions selected by bits 6, 5 and 4 holds. With none of those bits set, it always skips.
- R5: In the skip group, the conditions are tested on the incoming accumulator. Bit 7 (clear) then makes the accumulator output 0. Otherwise the accumulator passes through. The MQ always passes through.
- R6: On a skip, `pc_o` is `pc_i` with its low 12 bits incremented modulo 4096 and its upper field bits kept. Without a skip, `pc_o` equals `pc_i`.
- R7: A legal skip-group instruction with bit 1 set raises `halt_o` after the accepting edge. `halt_o` stays high until an edge where `cont_i` is high. If a new halt request arrives at the same edge as `cont_i`, the halt request wins.
- R8: The MQ group is encoded as bits 11:9 = 7, bit 8 = 1 and bit 0 = 1. Bit 7 clears the accumulator first. Bit 6 then makes the accumulator output equal (cleared accumulator) OR MQ.
- R9: In the MQ group, bit 4 loads the MQ with the accumulator value after the clear step but before the OR. This lets bits 6 and 4 exchange the two registers in one instruction.
- R10: A skip-group instruction with bit 2 set is illegal. So is an MQ-group instruction with any of bits 5, 3, 2 or 1 set. Either case behaves as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Instruction accept strobe |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Current accumulator |
| link_i | input | 1 | Current link bit |
| mq_i | input | 12 | Current MQ register |
| pc_i | input | 15 | Next program counter (field bits 14:12, offset 11:0) |
| cont_i | input | 1 | Continue, clears the halt output |
| res_valid_o | output | 1 | Result strobe, one cycle |
| skip_o | output | 1 | Skip taken |
| pc_o | output | 15 | Resulting program counter |
| acc_o | output | 12 | Resulting accumulator |
| mq_o | output | 12 | Resulting MQ |
| illegal_o | output | 1 | Unsupported or foreign instruction |
| halt_o | output | 1 | Sticky halt flag |

## Verification
Every data result, the skip flag and the illegal flag are due one edge after the accepting edge. The halt flag rises at that same edge and falls one edge after `cont_i` is sampled high. The bench drives inputs on the falling edge and reads outputs on the next falling edge, which lies exactly one rising edge later. After every accept it drops `valid_i` again, so the strobe and hold behaviour can be observed. Internal reset release takes two extra edges, and the bench waits these out before its first instruction.

// File: rtl/opr23_pkg.sv
package opr23_pkg;
  // Instruction word geometry: fixed by the 12-bit instruction format.
  localparam int WORD_W  = 12;
  localparam int OP_W    = 3;
  localparam int OP_LSB  = WORD_W - OP_W;
  localparam logic [OP_W-1:0] OP_OPERATE = 3'd7;

  // Bit positions inside the operate word.
  localparam int B_GRP   = 8;  // 1: skip/MQ groups
  localparam int B_CLR   = 7;
  localparam int B_NEG   = 6;  // sign test / MQ-to-acc
  localparam int B_ZERO  = 5;
  localparam int B_LNK   = 4;  // link test / acc-to-MQ
  localparam int B_SENSE = 3;
  localparam int B_SWR   = 2;
  localparam int B_STOP  = 1;
  localparam int B_G3    = 0;

  // Extended-arithmetic bits of the MQ group.
  localparam logic [WORD_W-1:0] EXT_MASK = 12'o0056;

  typedef struct packed {
    logic is_skip;   // skip-group instruction, legal
    logic is_mq;     // MQ-group instruction, legal
    logic bad;       // not executable here
    logic clr;
    logic t_neg;
    logic t_zero;
    logic t_link;
    logic invert;
    logic stop;
    logic mq_to_acc;
    logic acc_to_mq;
  } opr_ctl_t;
endpackage

// File: rtl/opr23_rst_sync.sv
module opr23_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/opr23_decode.sv
module opr23_decode
  import opr23_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  output opr_ctl_t          ctl
);
  logic operate;
  logic skip_grp;
  logic mq_grp;
  logic skip_bad;
  logic mq_bad;

  always_comb begin
    operate  = (instr[WORD_W-1:OP_LSB] == OP_OPERATE) && instr[B_GRP];
    skip_grp = operate && !instr[B_G3];
    mq_grp   = operate &&  instr[B_G3];
    skip_bad = skip_grp && instr[B_SWR];
    mq_bad   = mq_grp && ((instr & EXT_MASK) != '0);

    ctl           = '0;
    ctl.bad       = !operate || skip_bad || mq_bad;
    ctl.is_skip   = skip_grp && !skip_bad;
    ctl.is_mq     = mq_grp && !mq_bad;
    ctl.clr       = instr[B_CLR];
    ctl.t_neg     = instr[B_NEG];
    ctl.t_zero    = instr[B_ZERO];
    ctl.t_link    = instr[B_LNK];
    ctl.invert    = instr[B_SENSE];
    ctl.stop      = instr[B_STOP];
    ctl.mq_to_acc = instr[B_NEG];
    ctl.acc_to_mq = instr[B_LNK];
  end
endmodule

// File: rtl/opr23_skip_eval.sv
module opr23_skip_eval #(
  parameter int WORD_W = 12
) (
  input  logic              t_neg,
  input  logic              t_zero,
  input  logic              t_link,
  input  logic              invert,
  input  logic [WORD_W-1:0] acc,
  input  logic              link,
  output logic              skip
);
  logic any_hit;

  always_comb begin
    any_hit = (t_neg  && acc[WORD_W-1]) ||
              (t_zero && (acc == '0))   ||
              (t_link && link);
    skip    = invert ? !any_hit : any_hit;
  end
endmodule

// File: rtl/opr23_mq_xfer.sv
module opr23_mq_xfer #(
  parameter int WORD_W = 12
) (
  input  logic              clr,
  input  logic              mq_to_acc,
  input  logic              acc_to_mq,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] mq,
  output logic [WORD_W-1:0] acc_n,
  output logic [WORD_W-1:0] mq_n
);
  logic [WORD_W-1:0] acc_c;

  always_comb begin
    acc_c = clr ? '0 : acc;
    acc_n = mq_to_acc ? (acc_c | mq) : acc_c;
    mq_n  = acc_to_mq ? acc_c : mq;
  end
endmodule

// File: rtl/opr23_pc_step.sv
module opr23_pc_step #(
  parameter int OFS_W   = 12,
  parameter int FIELD_W = 3
) (
  input  logic [FIELD_W+OFS_W-1:0] pc,
  input  logic                     step,
  output logic [FIELD_W+OFS_W-1:0] pc_n
);
  logic [OFS_W-1:0] ofs_inc;

  always_comb begin
    ofs_inc = pc[OFS_W-1:0] + {{(OFS_W-1){1'b0}}, 1'b1};
    pc_n    = step ? {pc[FIELD_W+OFS_W-1:OFS_W], ofs_inc} : pc;
  end
endmodule

// File: rtl/opr23_unit.sv
module opr23_unit
  import opr23_pkg::*;
#(
  parameter int FIELD_W  = 3,
  parameter int SYNC_LEN = 2,
  localparam int PC_W    = FIELD_W + WORD_W
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              link_i,
  input  logic [WORD_W-1:0] mq_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              cont_i,
  output logic              res_valid_o,
  output logic              skip_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0] mq_o,
  output logic              illegal_o,
  output logic              halt_o
);
  logic rst_n_s;

  opr23_rst_sync #(.STAGES(SYNC_LEN)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n_o(rst_n_s)
  );

  opr_ctl_t ctl;
  opr23_decode u_dec (.instr(instr_i), .ctl(ctl));

  logic skip_raw;
  opr23_skip_eval #(.WORD_W(WORD_W)) u_skip (
    .t_neg(ctl.t_neg), .t_zero(ctl.t_zero), .t_link(ctl.t_link),
    .invert(ctl.invert), .acc(acc_i), .link(link_i), .skip(skip_raw)
  );

  logic [WORD_W-1:0] g3_acc;
  logic [WORD_W-1:0] g3_mq;
  opr23_mq_xfer #(.WORD_W(WORD_W)) u_mq (
    .clr(ctl.clr), .mq_to_acc(ctl.mq_to_acc), .acc_to_mq(ctl.acc_to_mq),
    .acc(acc_i), .mq(mq_i), .acc_n(g3_acc), .mq_n(g3_mq)
  );

  logic            skip_d;
  logic [PC_W-1:0] pc_d;
  assign skip_d = ctl.is_skip && skip_raw;

  opr23_pc_step #(.OFS_W(WORD_W), .FIELD_W(FIELD_W)) u_pc (
    .pc(pc_i), .step(skip_d), .pc_n(pc_d)
  );

  // Next-state logic
  logic [WORD_W-1:0] acc_d;
  logic [WORD_W-1:0] mq_d;
  logic              halt_d;
  logic              halt_set;

  always_comb begin
    acc_d = acc_i;
    mq_d  = mq_i;
    if (ctl.is_skip) begin
      acc_d = ctl.clr ? '0 : acc_i;
    end else if (ctl.is_mq) begin
      acc_d = g3_acc;
      mq_d  = g3_mq;
    end
    halt_set = valid_i && ctl.is_skip && ctl.stop;
    if (halt_set)    halt_d = 1'b1;
    else if (cont_i) halt_d = 1'b0;
    else             halt_d = halt_o;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      res_valid_o <= 1'b0;
      halt_o      <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      halt_o      <= halt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      skip_o    <= 1'b0;
      pc_o      <= '0;
      acc_o     <= '0;
      mq_o      <= '0;
      illegal_o <= 1'b0;
    end else if (valid_i) begin
      skip_o    <= skip_d;
      pc_o      <= pc_d;
      acc_o     <= acc_d;
      mq_o      <= mq_d;
      illegal_o <= ctl.bad;
    end
  end
endmodule

// File: rtl/opr23_checker.sv
module opr23_checker #(
  parameter int WORD_W = 12,
  parameter int PC_W   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [WORD_W-1:0] instr_i,
  input logic [WORD_W-1:0] acc_i,
  input logic [WORD_W-1:0] mq_i,
  input logic [PC_W-1:0]   pc_i,
  input logic              cont_i,
  input logic              res_valid_o,
  input logic              skip_o,
  input logic [PC_W-1:0]   pc_o,
  input logic [WORD_W-1:0] acc_o,
  input logic [WORD_W-1:0] mq_o,
  input logic              illegal_o,
  input logic              halt_o
);
  assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o == $past(valid_i));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(acc_o) && $stable(mq_o) && $stable(pc_o) && $stable(skip_o)));

  assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (skip_o ?
      (pc_o[PC_W-1:WORD_W] == $past(pc_i[PC_W-1:WORD_W]) &&
       pc_o[WORD_W-1:0] == $past(pc_i[WORD_W-1:0]) + 1'b1) :
      (pc_o == $past(pc_i))));

  assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (!illegal_o ||
      (!skip_o && acc_o == $past(acc_i) && mq_o == $past(mq_i))));

  assert_always_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (instr_i & 12'o7575) == 12'o7410) |=> skip_o);

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !cont_i) |=> halt_o);

  assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> ($past(valid_i) && !illegal_o && $past(instr_i[1])));

  assert_cont_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_i && !valid_i) |=> !halt_o);
endmodule

bind opr23_unit opr23_checker #(.WORD_W(opr23_pkg::WORD_W), .PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .valid_i(valid_i), .instr_i(instr_i),
  .acc_i(acc_i), .mq_i(mq_i), .pc_i(pc_i), .cont_i(cont_i),
  .res_valid_o(res_valid_o), .skip_o(skip_o), .pc_o(pc_o), .acc_o(acc_o),
  .mq_o(mq_o), .illegal_o(illegal_o), .halt_o(halt_o)
);

// File: tb/opr23_unit_bench.sv
module opr23_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        valid_i;
  logic [11:0] instr_i;
  logic [11:0] acc_i;
  logic        link_i;
  logic [11:0] mq_i;
  logic [14:0] pc_i;
  logic        cont_i;
  logic        res_valid_o;
  logic        skip_o;
  logic [14:0] pc_o;
  logic [11:0] acc_o;
  logic [11:0] mq_o;
  logic        illegal_o;
  logic        halt_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opr23_unit u_opr23_unit (
    .clk(clk), .arst_n(arst_n), .valid_i(valid_i), .instr_i(instr_i),
    .acc_i(acc_i), .link_i(link_i), .mq_i(mq_i), .pc_i(pc_i), .cont_i(cont_i),
    .res_valid_o(res_valid_o), .skip_o(skip_o), .pc_o(pc_o), .acc_o(acc_o),
    .mq_o(mq_o), .illegal_o(illegal_o), .halt_o(halt_o)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0o expected %0o", req, what, act, exp);
    end
  endtask

  // Apply one instruction, wait one rising edge, check all results.
  task automatic run(string req, logic [11:0] ins, logic [11:0] a, logic l,
                     logic [11:0] m, logic [14:0] p, logic e_skip,
                     logic [11:0] e_acc, logic [11:0] e_mq, logic [14:0] e_pc,
                     logic e_ill);
    instr_i = ins; acc_i = a; link_i = l; mq_i = m; pc_i = p; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, "res_valid", 16'(res_valid_o), 16'd1);
    check(req, "skip",      16'(skip_o),      16'(e_skip));
    check(req, "acc",       16'(acc_o),       16'(e_acc));
    check(req, "mq",        16'(mq_o),        16'(e_mq));
    check(req, "pc",        16'(pc_o),        16'(e_pc));
    check(req, "illegal",   16'(illegal_o),   16'(e_ill));
  endtask

  task automatic t_reset();
    check("R1", "reset res_valid", 16'(res_valid_o), 16'd0);
    check("R1", "reset acc",  16'(acc_o),  16'd0);
    check("R1", "reset pc",   16'(pc_o),   16'd0);
    check("R1", "reset halt", 16'(halt_o), 16'd0);
  endtask

  task automatic t_or_sense();
    run("R3", 12'o7500, 12'o4000, 1'b0, 12'o0, 15'o00101, 1'b1, 12'o4000, 12'o0, 15'o00102, 1'b0);
    run("R3", 12'o7500, 12'o3777, 1'b0, 12'o0, 15'o00101, 1'b0, 12'o3777, 12'o0, 15'o00101, 1'b0);
    run("R3", 12'o7440, 12'o0000, 1'b0, 12'o0, 15'o10200, 1'b1, 12'o0000, 12'o0, 15'o10201, 1'b0);
    run("R3", 12'o7440, 12'o0001, 1'b1, 12'o0, 15'o10200, 1'b0, 12'o0001, 12'o0, 15'o10200, 1'b0);
    run("R3", 12'o7420, 12'o0123, 1'b1, 12'o0, 15'o00050, 1'b1, 12'o0123, 12'o0, 15'o00051, 1'b0);
    run("R3", 12'o7560, 12'o0123, 1'b0, 12'o0, 15'o00050, 1'b0, 12'o0123, 12'o0, 15'o00050, 1'b0);
    run("R3", 12'o7400, 12'o0000, 1'b1, 12'o0, 15'o00050, 1'b0, 12'o0000, 12'o0, 15'o00050, 1'b0);
  endtask

  task automatic t_inverted();
    run("R4", 12'o7510, 12'o4000, 1'b0, 12'o0, 15'o00300, 1'b0, 12'o4000, 12'o0, 15'o00300, 1'b0);
    run("R4", 12'o7510, 12'o0377, 1'b0, 12'o0, 15'o00300, 1'b1, 12'o0377, 12'o0, 15'o00301, 1'b0);
    run("R4", 12'o7410, 12'o4000, 1'b1, 12'o0, 15'o00300, 1'b1, 12'o4000, 12'o0, 15'o00301, 1'b0);
    run("R4", 12'o7450, 12'o0000, 1'b0, 12'o0, 15'o00300, 1'b0, 12'o0000, 12'o0, 15'o00300, 1'b0);
    run("R4", 12'o7430, 12'o0007, 1'b1, 12'o0, 15'o00300, 1'b0, 12'o0007, 12'o0, 15'o00300, 1'b0);
    run("R4", 12'o7430, 12'o0007, 1'b0, 12'o0, 15'o00300, 1'b1, 12'o0007, 12'o0, 15'o00301, 1'b0);
  endtask

  task automatic t_clear_after_test();
    run("R5", 12'o7640, 12'o0005, 1'b0, 12'o0666, 15'o00020, 1'b0, 12'o0000, 12'o0666, 15'o00020, 1'b0);
    run("R5", 12'o7650, 12'o0005, 1'b0, 12'o0666, 15'o00020, 1'b1, 12'o0000, 12'o0666, 15'o00021, 1'b0);
  endtask

  task automatic t_pc_wrap();
    run("R6", 12'o7410, 12'o0001, 1'b0, 12'o0, 15'o37777, 1'b1, 12'o0001, 12'o0, 15'o30000, 1'b0);
  endtask

  task automatic t_halt();
    run("R7", 12'o7402, 12'o0012, 1'b0, 12'o0, 15'o00400, 1'b0, 12'o0012, 12'o0, 15'o00400, 1'b0);
    check("R7", "halt set", 16'(halt_o), 16'd1);
    run("R7", 12'o7440, 12'o0000, 1'b0, 12'o0, 15'o00400, 1'b1, 12'o0000, 12'o0, 15'o00401, 1'b0);
    check("R7", "halt held", 16'(halt_o), 16'd1);
    cont_i = 1'b1;
    @(negedge clk);
    cont_i = 1'b0;
    check("R7", "halt cleared", 16'(halt_o), 16'd0);
    cont_i = 1'b1;
    run("R7", 12'o7412, 12'o0000, 1'b0, 12'o0, 15'o00400, 1'b1, 12'o0000, 12'o0, 15'o00401, 1'b0);
    cont_i = 1'b0;
    check("R7", "halt wins over continue", 16'(halt_o), 16'd1);
    cont_i = 1'b1;
    @(negedge clk);
    cont_i = 1'b0;
    check("R7", "halt cleared again", 16'(halt_o), 16'd0);
  endtask

  task automatic t_mq_group();
    run("R8", 12'o7701, 12'o1234, 1'b0, 12'o4321, 15'o00010, 1'b0, 12'o4321, 12'o4321, 15'o00010, 1'b0);
    run("R8", 12'o7501, 12'o1200, 1'b0, 12'o0034, 15'o00010, 1'b0, 12'o1234, 12'o0034, 15'o00010, 1'b0);
    run("R9", 12'o7421, 12'o5555, 1'b0, 12'o1111, 15'o00010, 1'b0, 12'o5555, 12'o5555, 15'o00010, 1'b0);
    run("R9", 12'o7521, 12'o0070, 1'b0, 12'o0700, 15'o00010, 1'b0, 12'o0770, 12'o0070, 15'o00010, 1'b0);
    run("R9", 12'o7621, 12'o1234, 1'b0, 12'o7777, 15'o00010, 1'b0, 12'o0000, 12'o0000, 15'o00010, 1'b0);
    run("R9", 12'o7721, 12'o1234, 1'b0, 12'o0456, 15'o00010, 1'b0, 12'o0456, 12'o0000, 15'o00010, 1'b0);
  endtask

  task automatic t_illegal();
    run("R10", 12'o7404, 12'o0000, 1'b0, 12'o0222, 15'o00070, 1'b0, 12'o0000, 12'o0222, 15'o00070, 1'b1);
    run("R10", 12'o7616, 12'o0044, 1'b0, 12'o0222, 15'o00070, 1'b0, 12'o0044, 12'o0222, 15'o00070, 1'b1);
    check("R10", "no halt from illegal", 16'(halt_o), 16'd0);
    run("R10", 12'o7723, 12'o0044, 1'b0, 12'o0222, 15'o00070, 1'b0, 12'o0044, 12'o0222, 15'o00070, 1'b1);
    run("R10", 12'o7541, 12'o0044, 1'b0, 12'o0222, 15'o00070, 1'b0, 12'o0044, 12'o0222, 15'o00070, 1'b1);
    run("R2",  12'o5123, 12'o0044, 1'b1, 12'o0222, 15'o00070, 1'b0, 12'o0044, 12'o0222, 15'o00070, 1'b1);
    run("R2",  12'o7200, 12'o0044, 1'b1, 12'o0222, 15'o00070, 1'b0, 12'o0044, 12'o0222, 15'o00070, 1'b1);
  endtask

  task automatic t_hold();
    run("R1", 12'o7410, 12'o0333, 1'b0, 12'o0444, 15'o00555, 1'b1, 12'o0333, 12'o0444, 15'o00556, 1'b0);
    instr_i = 12'o7701; acc_i = 12'o7777; mq_i = 12'o1111; pc_i = 15'o77777;
    @(negedge clk);
    check("R1", "strobe low when idle", 16'(res_valid_o), 16'd0);
    check("R1", "acc held", 16'(acc_o), 16'o0333);
    check("R1", "mq held",  16'(mq_o),  16'o0444);
    check("R1", "pc held",  16'(pc_o),  16'o00556);
    check("R1", "skip held", 16'(skip_o), 16'd1);
  endtask

  initial begin
    arst_n = 1'b0; valid_i = 1'b0; cont_i = 1'b0;
    instr_i = '0; acc_i = '0; link_i = 1'b0; mq_i = '0; pc_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_or_sense();
    t_inverted();
    t_clear_after_test();
    t_pc_wrap();
    t_halt();
    t_mq_group();
    t_illegal();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule